// File: doc/BRIEF.md
# Serial Boot Link Autobaud Handshake

This block brings up a serial boot link whose bit rate is not known in advance. After reset it lets the line settle for a fixed number of clocks, then waits for the host to send 0x00 frames (8 data bits, one stop bit, no parity, asynchronous). It times how long the receive line stays low across the start bit and the eight zero data bits, and divides that span by nine to get the number of clocks per bit.

The divisor drives the block's own small transmitter and receiver. The transmitter sends a single 0x00 frame to tell the host that the rate is set. The receiver then waits for a 0x55 frame, sampled at the middle of each bit. A clean 0x55 locks the link. Any other result halts the block until the next reset.

At the moment of lock, the block samples a blank-check input. It raises an erase request if the memory behind it is not fully erased. The divisor stays on an output so that later protocol logic can reuse it.

Top module: `boot_autobaud`

## Requirements
- R1: While reset is held and right after it, txd is 1, locked, erase_req and fail are 0, and baud_div is 0.
- R2: For the first SETTLE_CYCLES (default 100) clocks after reset, rxd is ignored. A low level present at reset release or during settling is never timed. Timing starts at the first high-to-low transition after the line has been seen high once settling has finished.
- R3: With L the number of clocks that the synchronised rxd stays low, baud_div becomes floor((L+4)/9), which is L/9 rounded to nearest. The value appears once the line returns high.
- R4: A low span shorter than 9*MIN_BIT_CLKS clocks (144 by default) sets fail when it ends. A span that passes 2^CNT_W-1 clocks sets fail while the line is still low.
- R5: After a valid measurement, txd carries exactly one frame: a 0 start bit, eight 0 data bits and a 1 stop bit, each lasting baud_div clocks. At all other times txd stays 1.
- R6: The confirmation receiver is armed only after the acknowledge frame's stop bit has been sent. It samples each bit at mid-bit using baud_div, least significant bit first, so a bit-reversed 0xAA is a different value.
- R7: A received 0x55 with a 1 stop bit sets locked, which then stays 1 until reset.
- R8: Any other received value, or a 0 stop bit, sets fail. fail stays 1 until reset, txd stays 1, and later frames are ignored.
- R9: erase_req rises in the same cycle as locked when blank_all_ones is 0 at that moment. It stays 0 if blank_all_ones is 1.
- R10: locked and fail are never both 1, and baud_div does not change once locked is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line from the host |
| blank_all_ones | input | 1 | High when the memory is fully erased |
| txd | output | 1 | Serial line to the host, idles high |
| baud_div | output | CNT_W | Clocks per bit, as measured |
| locked | output | 1 | Handshake completed |
| erase_req | output | 1 | Erase-all request, raised at lock |
| fail | output | 1 | Handshake failed, halted until reset |

## Verification
The bench aims at the span limits: 143 and 144 clocks, and 4095 and 4096 clocks with CNT_W=12. A design with an off-by-one compare would accept a span that is too short, or cut off the longest legal one. Random spans that are not multiples of nine check the rounding; truncating instead of rounding shows up as a divisor one too low. A low level at reset release and a glitch during settling would, if timed, produce a wrong divisor or a spurious failure. Bit-reversed, wrong-value and bad-stop confirmations must fail for good, and a second acknowledge frame shows up as extra low bits on txd.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

    // start bit plus eight zero data bits of a 0x00 frame
    localparam int unsigned SPAN_BITS    = 9;
    localparam logic [7:0]  ACK_BYTE     = 8'h00;
    localparam logic [7:0]  CONFIRM_BYTE = 8'h55;

    typedef enum logic [2:0] {
        TOP_MEASURE,
        TOP_ACK_START,
        TOP_ACK_WAIT,
        TOP_CONFIRM,
        TOP_LOCKED,
        TOP_FAILED
    } top_state_e;

    typedef enum logic [2:0] {
        MS_SETTLE,
        MS_ARM,
        MS_EDGE,
        MS_COUNT,
        MS_HOLD
    } meter_state_e;

    typedef enum logic [2:0] {
        RX_OFF,
        RX_WAIT_HIGH,
        RX_WAIT_EDGE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_END
    } rx_state_e;

endpackage

// File: rtl/ab_span_meter.sv
module ab_span_meter
    import autobaud_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 100,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned MIN_BIT_CLKS  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd_s,
    output logic             done,
    output logic             err,
    output logic [CNT_W-1:0] div
);

    localparam int unsigned SETTLE_W = $clog2(SETTLE_CYCLES + 1);
    localparam int unsigned MIN_SPAN = SPAN_BITS * MIN_BIT_CLKS;

    typedef struct packed {
        meter_state_e        st;
        logic [SETTLE_W-1:0] settle;
        logic [CNT_W-1:0]    span;
        logic [CNT_W-1:0]    div;
        logic                done;
        logic                err;
    } meter_regs_t;

    meter_regs_t q, d;

    logic [CNT_W:0] rnd_sum;
    logic [CNT_W:0] rnd_quot;

    // round to nearest: (span + 4) / 9
    assign rnd_sum  = {1'b0, q.span} + (CNT_W+1)'(4);
    assign rnd_quot = rnd_sum / (CNT_W+1)'(SPAN_BITS);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            MS_SETTLE: begin
                if (q.settle == SETTLE_W'(SETTLE_CYCLES - 1)) d.st = MS_ARM;
                else d.settle = q.settle + SETTLE_W'(1);
            end
            MS_ARM: begin
                if (rxd_s) d.st = MS_EDGE;
            end
            MS_EDGE: begin
                if (!rxd_s) begin
                    d.st   = MS_COUNT;
                    d.span = CNT_W'(1);
                end
            end
            MS_COUNT: begin
                if (!rxd_s) begin
                    if (q.span == {CNT_W{1'b1}}) begin
                        d.err = 1'b1;
                        d.st  = MS_HOLD;
                    end else begin
                        d.span = q.span + CNT_W'(1);
                    end
                end else begin
                    d.st = MS_HOLD;
                    if (q.span < CNT_W'(MIN_SPAN)) begin
                        d.err = 1'b1;
                    end else begin
                        d.div  = rnd_quot[CNT_W-1:0];
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = MS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: MS_SETTLE, settle: '0, span: '0, div: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign err  = q.err;
    assign div  = q.div;

endmodule

// File: rtl/ab_uart_tx.sv
module ab_uart_tx #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       data,
    input  logic [DIV_W-1:0] div,
    output logic             txd,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic [9:0]       frame;
        logic [3:0]       idx;
        logic [DIV_W-1:0] cnt;
        logic             done;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.frame = {1'b1, data, 1'b0};
                d.idx   = 4'd0;
                d.cnt   = div - DIV_W'(1);
            end
        end else if (q.cnt == '0) begin
            if (q.idx == 4'd9) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.idx   = q.idx + 4'd1;
                d.frame = {1'b1, q.frame[9:1]};
                d.cnt   = div - DIV_W'(1);
            end
        end else begin
            d.cnt = q.cnt - DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, frame: '1, idx: '0, cnt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign txd  = q.busy ? q.frame[0] : 1'b1;
    assign busy = q.busy;
    assign done = q.done;

endmodule

// File: rtl/ab_uart_rx.sv
module ab_uart_rx
    import autobaud_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rxd_s,
    input  logic [DIV_W-1:0] div,
    output logic             done,
    output logic [7:0]       data,
    output logic             stop_ok
);

    typedef struct packed {
        rx_state_e        st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       shreg;
        logic             done;
        logic             stop_ok;
    } rx_regs_t;

    rx_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            RX_OFF: begin
                if (arm) d.st = RX_WAIT_HIGH;
            end
            RX_WAIT_HIGH: begin
                if (rxd_s) d.st = RX_WAIT_EDGE;
            end
            RX_WAIT_EDGE: begin
                if (!rxd_s) begin
                    d.st  = RX_START;
                    d.cnt = div >> 1;
                end
            end
            RX_START: begin
                if (q.cnt == '0) begin
                    if (rxd_s) begin
                        d.st = RX_WAIT_EDGE;
                    end else begin
                        d.st  = RX_DATA;
                        d.idx = 3'd0;
                        d.cnt = div - DIV_W'(1);
                    end
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            RX_DATA: begin
                if (q.cnt == '0) begin
                    d.shreg = {rxd_s, q.shreg[7:1]};
                    d.cnt   = div - DIV_W'(1);
                    if (q.idx == 3'd7) d.st = RX_STOP;
                    else d.idx = q.idx + 3'd1;
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            RX_STOP: begin
                if (q.cnt == '0) begin
                    d.done    = 1'b1;
                    d.stop_ok = rxd_s;
                    d.st      = RX_END;
                end else begin
                    d.cnt = q.cnt - DIV_W'(1);
                end
            end
            default: d.st = RX_END;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_OFF, cnt: '0, idx: '0, shreg: '0, done: 1'b0, stop_ok: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign data    = q.shreg;
    assign stop_ok = q.stop_ok;

endmodule

// File: rtl/boot_autobaud.sv
module boot_autobaud
    import autobaud_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 100,
    parameter int unsigned CNT_W         = 16,
    parameter int unsigned MIN_BIT_CLKS  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             blank_all_ones,
    output logic             txd,
    output logic [CNT_W-1:0] baud_div,
    output logic             locked,
    output logic             erase_req,
    output logic             fail
);

    typedef struct packed {
        top_state_e       st;
        logic [1:0]       sync;
        logic [CNT_W-1:0] div;
        logic             locked;
        logic             erase;
        logic             fail;
    } top_regs_t;

    top_regs_t q, d;

    logic             rxd_s;
    logic             m_done, m_err;
    logic [CNT_W-1:0] m_div;
    logic             tx_start, tx_busy, tx_done;
    logic             rx_arm, rx_done, rx_stop_ok;
    logic [7:0]       rx_data;

    assign rxd_s    = q.sync[1];
    assign tx_start = (q.st == TOP_ACK_START);
    assign rx_arm   = (q.st == TOP_CONFIRM);

    ab_span_meter #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .CNT_W         (CNT_W),
        .MIN_BIT_CLKS  (MIN_BIT_CLKS)
    ) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .rxd_s (rxd_s),
        .done  (m_done),
        .err   (m_err),
        .div   (m_div)
    );

    ab_uart_tx #(.DIV_W(CNT_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .data  (ACK_BYTE),
        .div   (q.div),
        .txd   (txd),
        .busy  (tx_busy),
        .done  (tx_done)
    );

    ab_uart_rx #(.DIV_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (rx_arm),
        .rxd_s   (rxd_s),
        .div     (q.div),
        .done    (rx_done),
        .data    (rx_data),
        .stop_ok (rx_stop_ok)
    );

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], rxd};
        case (q.st)
            TOP_MEASURE: begin
                if (m_err) begin
                    d.fail = 1'b1;
                    d.st   = TOP_FAILED;
                end else if (m_done) begin
                    d.div = m_div;
                    d.st  = TOP_ACK_START;
                end
            end
            TOP_ACK_START: begin
                if (tx_busy) d.st = TOP_ACK_WAIT;
            end
            TOP_ACK_WAIT: begin
                if (tx_done) d.st = TOP_CONFIRM;
            end
            TOP_CONFIRM: begin
                if (rx_done) begin
                    if (rx_stop_ok && (rx_data == CONFIRM_BYTE)) begin
                        d.locked = 1'b1;
                        d.erase  = ~blank_all_ones;
                        d.st     = TOP_LOCKED;
                    end else begin
                        d.fail = 1'b1;
                        d.st   = TOP_FAILED;
                    end
                end
            end
            default: d.st = q.st;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TOP_MEASURE, sync: 2'b11, div: '0,
                   locked: 1'b0, erase: 1'b0, fail: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign baud_div  = q.div;
    assign locked    = q.locked;
    assign erase_req = q.erase;
    assign fail      = q.fail;

endmodule

// File: rtl/boot_autobaud_chk.sv
module boot_autobaud_chk #(
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned MIN_BIT_CLKS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txd,
    input logic [CNT_W-1:0] baud_div,
    input logic             locked,
    input logic             erase_req,
    input logic             fail
);

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);

    a_r7_locked_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && fail));

    a_r8_txd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> txd);

    a_r10_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(baud_div));

    a_r9_erase_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> locked);

    a_r9_erase_with_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_req) |-> $rose(locked));

    a_r4_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (baud_div >= CNT_W'(MIN_BIT_CLKS)));

endmodule

bind boot_autobaud boot_autobaud_chk #(
    .CNT_W        (CNT_W),
    .MIN_BIT_CLKS (MIN_BIT_CLKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txd       (txd),
    .baud_div  (baud_div),
    .locked    (locked),
    .erase_req (erase_req),
    .fail      (fail)
);

// File: tb/boot_autobaud_tb.sv
`timescale 1ns/1ps
module boot_autobaud_tb;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          blank_all_ones = 1'b1;
    logic          txd;
    logic [CW-1:0] baud_div;
    logic          locked, erase_req, fail;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    boot_autobaud #(.SETTLE_CYCLES(100), .CNT_W(CW), .MIN_BIT_CLKS(16)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .rxd            (rxd),
        .blank_all_ones (blank_all_ones),
        .txd            (txd),
        .baud_div       (baud_div),
        .locked         (locked),
        .erase_req      (erase_req),
        .fail           (fail)
    );

    function automatic int exp_div(input int span);
        return (span + 4) / 9;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic line);
        @(negedge clk);
        rst_n = 1'b0;
        rxd = line;
        cyc(4);
        rst_n = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] b, input int p, input logic stop);
        rxd = 1'b0;
        cyc(p);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            cyc(p);
        end
        rxd = stop;
        cyc(p);
        rxd = 1'b1;
    endtask

    // receive one frame from txd at p clocks per bit
    task automatic get_ack(input int p, output int val, output bit stop_hi, output bit seen);
        int wait_n = 0;
        val = 0;
        stop_hi = 1'b0;
        seen = 1'b0;
        while (txd && wait_n < 3000) begin
            cyc(1);
            wait_n++;
        end
        if (!txd) begin
            seen = 1'b1;
            cyc(p / 2);
            for (int i = 0; i < 8; i++) begin
                cyc(p);
                val = val | (int'(txd) << i);
            end
            cyc(p);
            stop_hi = txd;
        end
    endtask

    // reset, settle, timing span of 9p, then read the acknowledge frame
    task automatic link_up(input int p, input logic blank, input string tag);
        int v;
        bit s, seen;
        blank_all_ones = blank;
        do_reset(1'b1);
        cyc(120);
        rxd = 1'b0;
        cyc(9 * p);
        rxd = 1'b1;
        get_ack(p, v, s, seen);
        chk(seen && v == 0 && s, {tag, " R5 ack frame 0x00"}, v, 0);
        chk(int'(baud_div) == p, {tag, " R3 divisor"}, int'(baud_div), p);
        cyc(p);
    endtask

    initial begin
        int v, p, span, lows;
        bit s, seen, blank;
        void'($urandom(32'd1234));

        // R1 reset state
        rst_n = 1'b0;
        cyc(3);
        chk(txd == 1'b1 && !locked && !erase_req && !fail && baud_div == 0,
            "R1 reset outputs", {txd, locked, erase_req, fail}, 8);
        rst_n = 1'b1;
        cyc(1);
        chk(txd == 1'b1 && baud_div == 0, "R1 after release", int'(baud_div), 0);

        // R7 R9 directed full handshake, not blank
        link_up(20, 1'b0, "dir");
        send_frame(8'h55, 20, 1'b1);
        cyc(4);
        chk(locked && !fail, "R7 lock on 0x55", locked, 1);
        chk(erase_req, "R9 erase when not blank", erase_req, 1);
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            cyc(1);
            if (!txd) lows++;
        end
        chk(lows == 0, "R5 single ack only", lows, 0);
        send_frame(8'h00, 20, 1'b1);
        cyc(4);
        chk(locked && int'(baud_div) == 20, "R7 lock holds", int'(baud_div), 20);

        // random handshakes
        for (int k = 0; k < 6; k++) begin
            p = 16 + int'($urandom % 60);
            blank = 1'($urandom % 2);
            link_up(p, blank, "rnd");
            send_frame(8'h55, p, 1'b1);
            cyc(4);
            chk(locked && !fail, "R7 random lock", locked, 1);
            chk(erase_req == !blank, "R9 erase vs blank", erase_req, int'(!blank));
        end

        // R3 rounding on random spans
        for (int k = 0; k < 8; k++) begin
            span = 144 + int'($urandom % 900);
            do_reset(1'b1);
            cyc(120);
            rxd = 1'b0;
            cyc(span);
            rxd = 1'b1;
            cyc(6);
            chk(int'(baud_div) == exp_div(span) && !fail, "R3 rounding", int'(baud_div), exp_div(span));
        end

        // R4 limits
        do_reset(1'b1);
        cyc(120);
        rxd = 1'b0;
        cyc(143);
        rxd = 1'b1;
        cyc(6);
        chk(fail && baud_div == 0, "R4 span 143 too short", fail, 1);
        chk(txd, "R8 txd idle after fail", txd, 1);

        do_reset(1'b1);
        cyc(120);
        rxd = 1'b0;
        cyc(144);
        rxd = 1'b1;
        cyc(6);
        chk(!fail && baud_div == 16, "R4 span 144 accepted", int'(baud_div), 16);

        do_reset(1'b1);
        cyc(120);
        rxd = 1'b0;
        cyc(4095);
        rxd = 1'b1;
        cyc(6);
        chk(!fail && baud_div == 455, "R4 span 4095 accepted", int'(baud_div), 455);

        do_reset(1'b1);
        cyc(120);
        rxd = 1'b0;
        cyc(4102);
        chk(fail, "R4 overflow fails while low", fail, 1);
        rxd = 1'b1;
        cyc(4);

        // R2 low during reset release and settling
        do_reset(1'b0);
        cyc(300);
        rxd = 1'b1;
        cyc(20);
        rxd = 1'b0;
        cyc(180);
        rxd = 1'b1;
        get_ack(20, v, s, seen);
        chk(seen && int'(baud_div) == 20 && !fail, "R2 low at reset not timed", int'(baud_div), 20);

        // R2 glitch inside the settling window
        do_reset(1'b1);
        cyc(10);
        rxd = 1'b0;
        cyc(50);
        rxd = 1'b1;
        cyc(60);
        rxd = 1'b0;
        cyc(270);
        rxd = 1'b1;
        cyc(6);
        chk(!fail && int'(baud_div) == 30, "R2 settle glitch ignored", int'(baud_div), 30);

        // R6 bit-reversed confirmation
        link_up(24, 1'b1, "rev");
        send_frame(8'hAA, 24, 1'b1);
        cyc(4);
        chk(fail && !locked, "R6 0xAA rejected", fail, 1);

        // R8 wrong value
        link_up(18, 1'b1, "bad");
        send_frame(8'h54, 18, 1'b1);
        cyc(4);
        chk(fail && !locked, "R8 0x54 rejected", fail, 1);

        // R8 framing error, then later 0x55 ignored
        link_up(22, 1'b0, "frm");
        send_frame(8'h55, 22, 1'b0);
        cyc(4);
        chk(fail && !locked, "R8 low stop rejected", fail, 1);
        cyc(40);
        send_frame(8'h55, 22, 1'b1);
        cyc(4);
        chk(fail && !locked && !erase_req && txd, "R8 halt until reset", locked, 0);

        // R10 exclusive flags after a good lock
        link_up(40, 1'b1, "ex");
        send_frame(8'h55, 40, 1'b1);
        cyc(4);
        chk(locked && !fail && !erase_req, "R10 lock without fail", fail, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule